// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Occupancy Flags

This block carries fixed-width words from a write clock domain into a separate read clock domain. Words enter through a write port that is gated by a ready flag. They are stored in a dual-port array and leave through an output register that loads itself. The first word written into an empty FIFO moves to the output register with no read request. From then on, a read consumes that word, and the register reloads from memory in the same read-clock edge whenever memory holds another word.

Each domain owns its own pair of flags. On the write side these are a ready flag and an active-low almost-full flag. On the read side they are an output-valid flag and an active-low almost-empty flag. Every flag is computed from the domain's own pointer and a Gray-coded copy of the far pointer, passed through two flops. A flag that leaves its boundary state therefore moves only after two edges of its own clock.

The almost-empty and almost-full thresholds are register offsets. A reset loads them with preset parameters. A small write-side configuration port can override them, but only until the first data word is accepted after reset.

Top module: `fifo_pflags`

## Requirements
- R1: After a write into an empty FIFO, the word appears on `rdata_o` and `rd_valid_o` rises with no read request. The output register holds it until a read is accepted.
- R2: The occupancy used by every flag counts only words in memory, never the word held in the output register. With n accepted words and no reads, occupancy is n-1 for n≥1, and 0 for n=0.
- R3: `rd_aempty_n_o` is low when occupancy ≤ X and high when occupancy ≥ X+1. X is the almost-empty offset.
- R4: `wr_afull_n_o` is low when occupancy ≥ DEPTH−Y and high below that. Y is the almost-full offset.
- R5: `wr_ready_o` is low exactly when occupancy equals DEPTH. The capacity is therefore DEPTH+1 words. A write while `wr_ready_o` is low is ignored and moves no pointer.
- R6: `rd_valid_o` is low when the output register is empty. A read while it is low is ignored and moves no pointer.
- R7: After the write that brings occupancy to X+1, `rd_aempty_n_o` is still low after the first rising edge of `rclk_i`. It goes high only on a later edge.
- R8: After a read from a full FIFO, `wr_ready_o` is still low after the first rising edge of `wclk_i`. It goes high only on a later edge.
- R9: Reset loads X=`X_PRESET` and Y=`Y_PRESET`. A configuration write with `cfg_sel_i`=0 sets X and one with `cfg_sel_i`=1 sets Y. Such a write is accepted only from reset until the first accepted data write; later configuration writes are ignored.
- R10: Words leave in the order they were accepted. While `rd_valid_o` is high and no read is requested, `rdata_o` is stable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk_i | input | 1 | Write-domain clock |
| rclk_i | input | 1 | Read-domain clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| wr_i | input | 1 | Write request |
| wdata_i | input | WIDTH | Write data |
| wr_ready_o | output | 1 | Memory not full (write domain) |
| wr_afull_n_o | output | 1 | Low when almost full (write domain) |
| cfg_we_i | input | 1 | Offset register write strobe (write domain) |
| cfg_sel_i | input | 1 | 0 selects X (almost-empty), 1 selects Y (almost-full) |
| cfg_data_i | input | log2(DEPTH) | Offset value |
| rd_i | input | 1 | Read request |
| rdata_o | output | WIDTH | Output register contents |
| rd_valid_o | output | 1 | Output register holds a word (read domain) |
| rd_aempty_n_o | output | 1 | Low when almost empty (read domain) |

## Verification
The bench runs a small 16-word configuration. It fills the FIFO one word at a time from empty to one write past capacity, then drains it word by word. At every occupancy level it compares all four flags against thresholds computed from the counts. Because every level is visited, an error of one at any boundary shows up: counting the output register as stored, or using < in place of ≤ for a threshold. The sweep is repeated with preset offsets and with offsets set through the configuration port, so the two threshold sources are told apart. A configuration write issued after data has started proves that the lock works. Dedicated probes sample a flag one edge after the crossing event, which separates a proper two-edge synchronizer from one that is too fast. Reads on an empty FIFO and writes on a full one are followed by data checks that would expose any pointer that moved.

// File: rtl/fifo_pflags_pkg.sv
package fifo_pflags_pkg;
  localparam logic CFG_SEL_AE = 1'b0;
  localparam logic CFG_SEL_AF = 1'b1;
endpackage

// File: rtl/fifo_pflags_sync.sv
module fifo_pflags_sync #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= gray_i;
      s2_q <= s1_q;
    end
  end

  always_comb begin
    for (int i = 0; i < W; i++) bin_o[i] = ^(s2_q >> i);
  end
endmodule

// File: rtl/fifo_pflags_ram.sv
module fifo_pflags_ram #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 36,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             wclk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/fifo_pflags_wr.sv
module fifo_pflags_wr #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW:0]   rptr_sync_i,
  input  logic [AW-1:0] y_off_i,
  output logic          wr_en_o,
  output logic [AW:0]   wptr_o,
  output logic [AW:0]   wgray_o,
  output logic          ready_o,
  output logic          afull_n_o
);
  localparam logic [AW:0] FULL_C = DEPTH[AW:0];

  logic [AW:0] wptr_q, wgray_q, wnext, wcount;

  assign wcount    = wptr_q - rptr_sync_i;
  assign ready_o   = (wcount != FULL_C);
  assign afull_n_o = ({1'b0, wcount} + {2'b00, y_off_i}) < {1'b0, FULL_C};
  assign wr_en_o   = wr_i & ready_o;
  assign wnext     = wptr_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      wgray_q <= '0;
    end else if (wr_en_o) begin
      wptr_q  <= wnext;
      wgray_q <= wnext ^ (wnext >> 1);
    end
  end

  assign wptr_o  = wptr_q;
  assign wgray_o = wgray_q;
endmodule

// File: rtl/fifo_pflags_rd.sv
module fifo_pflags_rd #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 36,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_i,
  input  logic [AW:0]      wptr_sync_i,
  input  logic [AW-1:0]    x_off_i,
  input  logic [WIDTH-1:0] mem_rdata_i,
  output logic [AW-1:0]    raddr_o,
  output logic [AW:0]      rgray_o,
  output logic [WIDTH-1:0] rdata_o,
  output logic             valid_o,
  output logic             aempty_n_o
);
  logic [AW:0]      rptr_q, rgray_q, rnext, rcount;
  logic [WIDTH-1:0] dout_q;
  logic             valid_q, rd_en, load;

  assign rcount = wptr_sync_i - rptr_q;
  assign rd_en  = rd_i & valid_q;
  // refill the output register when it empties or is being read
  assign load   = (rcount != '0) & (~valid_q | rd_en);
  assign rnext  = rptr_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_q  <= '0;
      rgray_q <= '0;
      valid_q <= 1'b0;
      dout_q  <= '0;
    end else if (load) begin
      rptr_q  <= rnext;
      rgray_q <= rnext ^ (rnext >> 1);
      valid_q <= 1'b1;
      dout_q  <= mem_rdata_i;
    end else if (rd_en) begin
      valid_q <= 1'b0;
    end
  end

  assign raddr_o    = rptr_q[AW-1:0];
  assign rgray_o    = rgray_q;
  assign rdata_o    = dout_q;
  assign valid_o    = valid_q;
  assign aempty_n_o = rcount > {1'b0, x_off_i};
endmodule

// File: rtl/fifo_pflags.sv
module fifo_pflags
  import fifo_pflags_pkg::*;
#(
  parameter int DEPTH    = 256,
  parameter int WIDTH    = 36,
  parameter int X_PRESET = 8,
  parameter int Y_PRESET = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             wclk_i,
  input  logic             rclk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic             wr_ready_o,
  output logic             wr_afull_n_o,
  input  logic             cfg_we_i,
  input  logic             cfg_sel_i,
  input  logic [AW-1:0]    cfg_data_i,
  input  logic             rd_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             rd_valid_o,
  output logic             rd_aempty_n_o
);
  logic [AW:0]      wptr_bin, wgray, rgray, wptr_sync, rptr_sync;
  logic [AW-1:0]    raddr, x_off_q, y_off_q;
  logic [WIDTH-1:0] mem_rdata;
  logic             wr_en, cfg_open_q;

  // offsets are static once data flows, so X is used directly in the read domain
  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_open_q <= 1'b1;
      x_off_q    <= X_PRESET[AW-1:0];
      y_off_q    <= Y_PRESET[AW-1:0];
    end else begin
      if (wr_en) cfg_open_q <= 1'b0;
      if (cfg_open_q && cfg_we_i) begin
        if (cfg_sel_i == CFG_SEL_AF) y_off_q <= cfg_data_i;
        else                         x_off_q <= cfg_data_i;
      end
    end
  end

  fifo_pflags_wr #(.DEPTH(DEPTH)) u_wr (
    .clk_i       (wclk_i),
    .rst_ni      (rst_ni),
    .wr_i        (wr_i),
    .rptr_sync_i (rptr_sync),
    .y_off_i     (y_off_q),
    .wr_en_o     (wr_en),
    .wptr_o      (wptr_bin),
    .wgray_o     (wgray),
    .ready_o     (wr_ready_o),
    .afull_n_o   (wr_afull_n_o)
  );

  fifo_pflags_sync #(.W(AW+1)) u_w2r (
    .clk_i  (rclk_i),
    .rst_ni (rst_ni),
    .gray_i (wgray),
    .bin_o  (wptr_sync)
  );

  fifo_pflags_sync #(.W(AW+1)) u_r2w (
    .clk_i  (wclk_i),
    .rst_ni (rst_ni),
    .gray_i (rgray),
    .bin_o  (rptr_sync)
  );

  fifo_pflags_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_ram (
    .wclk_i  (wclk_i),
    .we_i    (wr_en),
    .waddr_i (wptr_bin[AW-1:0]),
    .wdata_i (wdata_i),
    .raddr_i (raddr),
    .rdata_o (mem_rdata)
  );

  fifo_pflags_rd #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rd (
    .clk_i       (rclk_i),
    .rst_ni      (rst_ni),
    .rd_i        (rd_i),
    .wptr_sync_i (wptr_sync),
    .x_off_i     (x_off_q),
    .mem_rdata_i (mem_rdata),
    .raddr_o     (raddr),
    .rgray_o     (rgray),
    .rdata_o     (rdata_o),
    .valid_o     (rd_valid_o),
    .aempty_n_o  (rd_aempty_n_o)
  );
endmodule

// File: rtl/fifo_pflags_chk.sv
module fifo_pflags_chk #(
  parameter int AW = 8,
  parameter int W  = 36
) (
  input logic          wclk_i,
  input logic          rclk_i,
  input logic          rst_ni,
  input logic          wr_i,
  input logic          rd_i,
  input logic          wr_ready_o,
  input logic          rd_valid_o,
  input logic [W-1:0]  rdata_o,
  input logic [AW:0]   wptr_i,
  input logic [AW-1:0] x_i,
  input logic [AW-1:0] y_i
);
  assert_wr_ignored_R5: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (wr_i && !wr_ready_o) |=> (wptr_i == $past(wptr_i)));

  assert_ready_fall_R5: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    $fell(wr_ready_o) |-> $past(wr_i));

  assert_valid_hold_R6: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (rd_valid_o && !rd_i) |=> rd_valid_o);

  assert_valid_fall_R6: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    $fell(rd_valid_o) |-> $past(rd_i));

  assert_dout_hold_R10: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (rd_valid_o && !rd_i) |=> $stable(rdata_o));

  assert_cfg_locked_R9: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (wptr_i != '0) |=> ($stable(x_i) && $stable(y_i)));
endmodule

bind fifo_pflags fifo_pflags_chk #(.AW(AW), .W(WIDTH)) u_chk (
  .wclk_i     (wclk_i),
  .rclk_i     (rclk_i),
  .rst_ni     (rst_ni),
  .wr_i       (wr_i),
  .rd_i       (rd_i),
  .wr_ready_o (wr_ready_o),
  .rd_valid_o (rd_valid_o),
  .rdata_o    (rdata_o),
  .wptr_i     (wptr_bin),
  .x_i        (x_off_q),
  .y_i        (y_off_q)
);

// File: tb/fifo_pflags_test.sv
`timescale 1ns/100ps
module fifo_pflags_test;
  localparam int D  = 16;
  localparam int WD = 8;
  localparam int AW = 4;

  logic wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
  logic wr = 1'b0, rd = 1'b0, cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [WD-1:0] wdata = '0;
  logic [AW-1:0] cfg_data = '0;
  logic [WD-1:0] rdata;
  logic wr_ready, wr_afull_n, rd_valid, rd_aempty_n;

  int errors = 0, checks = 0;
  int x_cur, y_cur, acc;
  bit done = 1'b0;

  always #2.0 wclk = ~wclk;
  always #3.5 rclk = ~rclk;

  fifo_pflags #(.DEPTH(D), .WIDTH(WD), .X_PRESET(3), .Y_PRESET(4)) uut (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_n),
    .wr_i(wr), .wdata_i(wdata), .wr_ready_o(wr_ready), .wr_afull_n_o(wr_afull_n),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_data_i(cfg_data),
    .rd_i(rd), .rdata_o(rdata), .rd_valid_o(rd_valid), .rd_aempty_n_o(rd_aempty_n)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge rclk);
    @(negedge wclk);
  endtask

  // expected flags from memory occupancy m (R2) and output-register state
  task automatic check_flags(input int m, input bit vis);
    check("R5 wr_ready", int'(wr_ready), int'(m != D));
    check("R4/R2 wr_afull_n", int'(wr_afull_n), int'(m < D - y_cur));
    check("R3/R2 rd_aempty_n", int'(rd_aempty_n), int'(m > x_cur));
    check("R6 rd_valid", int'(rd_valid), int'(vis));
  endtask

  task automatic do_reset();
    wr = 0; rd = 0; cfg_we = 0;
    rst_n = 0;
    repeat (3) @(negedge wclk);
    rst_n = 1;
    settle();
  endtask

  task automatic fill(input int base, input bit probe);
    acc = 0;
    for (int a = 1; a <= D + 2; a++) begin
      @(negedge wclk);
      wr = 1; wdata = WD'(base + a);
      @(posedge wclk);
      #0.2 wr = 0;
      if (acc < D + 1) acc++;
      if (probe && acc == x_cur + 2 && a == acc) begin
        @(posedge rclk);
        #0.2 check("R7 aempty_n after one rclk edge", int'(rd_aempty_n), 0);
      end
      if (probe && a == 1) begin
        @(negedge wclk);
        cfg_we = 1; cfg_sel = 1'b0; cfg_data = 4'd1;
        @(negedge wclk);
        cfg_we = 0;
      end
      settle();
      check_flags(acc - 1, 1'b1);
      check("R1 first word in output reg", int'(rdata), base + 1);
    end
  endtask

  task automatic drain(input int base, input bit probe);
    for (int k = 0; k < acc; k++) begin
      @(negedge rclk);
      check("R10 order", int'(rdata), base + 1 + k);
      rd = 1;
      @(posedge rclk);
      if (probe && k == 0) begin
        @(posedge wclk);
        #0.2 check("R8 ready after one wclk edge", int'(wr_ready), 0);
      end
      #0.2 rd = 0;
      settle();
      begin
        int rem = acc - 1 - k;
        check_flags(rem > 0 ? rem - 1 : 0, rem > 0);
      end
    end
  endtask

  task automatic empty_read_then_write(input int val);
    @(negedge rclk);
    rd = 1;
    @(negedge rclk);
    rd = 0;
    settle();
    check("R6 valid stays low after ignored read", int'(rd_valid), 0);
    @(negedge wclk);
    wr = 1; wdata = WD'(val);
    @(negedge wclk);
    wr = 0;
    settle();
    check("R6 valid after write", int'(rd_valid), 1);
    check("R6 data not skipped", int'(rdata), val);
  endtask

  initial begin
    x_cur = 3; y_cur = 4;
    do_reset();
    // reset state (R9 presets)
    check_flags(0, 1'b0);
    fill(8'h10, 1'b0);
    drain(8'h10, 1'b0);
    empty_read_then_write(8'h77);

    // programmed offsets: cfg_sel 0 -> X, 1 -> Y (R9)
    do_reset();
    @(negedge wclk);
    cfg_we = 1; cfg_sel = 1'b0; cfg_data = 4'd5;
    @(negedge wclk);
    cfg_sel = 1'b1; cfg_data = 4'd2;
    @(negedge wclk);
    cfg_we = 0;
    x_cur = 5; y_cur = 2;
    settle();
    check("R9 aempty_n after programming", int'(rd_aempty_n), 0);
    fill(8'h40, 1'b1);
    drain(8'h40, 1'b1);
    empty_read_then_write(8'h99);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge wclk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule